// File: doc/BRIEF.md
# Next Program-Counter Selector

This block decides where a 32-bit processor fetches next. It looks at the 6-bit operation field at the top of the fetched instruction word and compares the two source operand values read for that instruction. From these it picks one of three addresses. The first is the sequential address, the current PC plus 4. The second is a PC-relative branch target, which adds a sign-extended, word-scaled 16-bit offset to PC+4. The third is a pseudo-direct jump target, which places the instruction's 26-bit index field under the top four bits of PC+4.

The selection logic is purely combinational. It also reports whether control flow was redirected, and whether the incoming PC is not word aligned. An optional register stage, selected by a parameter, holds a PC that loads the computed next address on every enabled clock edge. This stage lets the unit step through a program on its own in isolation.

Top module: `npc_unit`

## Requirements
- R1: Any operation field value other than 2, 4 or 5 yields next_pc_o = pc_i + 4 and taken_o = 0.
- R2: The sequential address wraps modulo 2^32, so pc_i = 0xFFFFFFFC gives PC+4 = 0x00000000.
- R3: Operation field 2 (bits 31:26) is an unconditional jump: taken_o = 1 and next_pc_o = {PC+4[31:28], instr_i[25:0], 2'b00}, whatever the operand values.
- R4: Operation field 4 branches when rs_val_i equals rt_val_i: taken_o = 1 and next_pc_o = PC+4 + (sign-extended instr_i[15:0] shifted left by 2).
- R5: Operation field 5 branches, with the same target as R4, when rs_val_i differs from rt_val_i.
- R6: A conditional branch whose condition fails yields next_pc_o = PC+4 and taken_o = 0.
- R7: The branch offset is a two's-complement value, so offsets with bit 15 set move the target backwards. The most negative offset is 0x8000, which is -131072 bytes.
- R8: misalign_o = 1 exactly when pc_i[1:0] is non-zero. The next-PC and taken results are unchanged by it.
- R9: With the register stage present, pc_q_o clears to 0 while rst_n is low, loads next_pc_o on a rising clk edge when pc_en is 1, and holds when pc_en is 0.
- R10: The jump's upper four bits come from PC+4, not from pc_i, so a PC of 0x0FFFFFFC jumps into the 0x1xxxxxxx region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional PC register |
| rst_n | input | 1 | Asynchronous active-low reset of the PC register |
| pc_en | input | 1 | Load enable of the PC register |
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| next_pc_o | output | 32 | Selected next program counter |
| taken_o | output | 1 | Control flow redirected (jump or taken branch) |
| misalign_o | output | 1 | Incoming PC is not word aligned |
| pc_q_o | output | 32 | Registered PC (equals next_pc_o if no register stage) |

## Verification
Errors in target formation show up on next_pc_o in the same cycle the instruction word is applied. These include a wrong sign extension, a missing shift, or upper bits taken from the wrong PC. Because each case produces a distinct address, the error is caught immediately. A wrong comparison sense shows up as a flipped taken_o together with a PC+4 versus target swap. A fault in the register stage only surfaces one edge later, as a pc_q_o that fails to follow or fails to hold. So every stimulus is also compared against a bench-side model of the register.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;
  localparam int unsigned ALIGN_W = 2;
  localparam int unsigned REGION_W = XLEN - JIDX_W - ALIGN_W;

  localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output flow_e            flow_o,
  output logic             br_on_eq_o
);
  always_comb begin
    flow_o     = FLOW_SEQ;
    br_on_eq_o = 1'b0;
    unique case (opcode_i)
      OPC_JUMP: flow_o = FLOW_JUMP;
      OPC_BEQ: begin
        flow_o     = FLOW_BRANCH;
        br_on_eq_o = 1'b1;
      end
      OPC_BNE: flow_o = FLOW_BRANCH;
      default: flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] diff;

  always_comb begin
    diff = a_i ^ b_i;
    eq_o = ~(|diff);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic [AW-1:0]     pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [AW-1:0]     seq_o,
  output logic [AW-1:0]     br_tgt_o,
  output logic [AW-1:0]     jmp_tgt_o
);
  localparam int unsigned SEXT_W = AW - IMM_W - ALIGN_W;
  localparam int unsigned TOP_W  = AW - JIDX_W - ALIGN_W;
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [AW-1:0] offset;

  always_comb begin
    seq_o     = pc_i + WORD_STEP;
    offset    = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    br_tgt_o  = seq_o + offset;
    jmp_tgt_o = {seq_o[AW-1 -: TOP_W], jidx_i, {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter bit REG_STAGE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_en,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            misalign_o,
  output logic [XLEN-1:0] pc_q_o
);
  flow_e           flow;
  logic            br_on_eq;
  logic            ops_eq;
  logic            br_hit;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  npc_decode u_dec (
    .opcode_i  (instr_i[XLEN-1 -: OPC_W]),
    .flow_o    (flow),
    .br_on_eq_o(br_on_eq)
  );

  npc_cmp #(.W(XLEN)) u_cmp (
    .a_i (rs_val_i),
    .b_i (rt_val_i),
    .eq_o(ops_eq)
  );

  npc_target #(.AW(XLEN)) u_tgt (
    .pc_i     (pc_i),
    .imm_i    (instr_i[IMM_W-1:0]),
    .jidx_i   (instr_i[JIDX_W-1:0]),
    .seq_o    (seq_pc),
    .br_tgt_o (br_tgt),
    .jmp_tgt_o(jmp_tgt)
  );

  always_comb begin
    br_hit     = (flow == FLOW_BRANCH) && (ops_eq == br_on_eq);
    misalign_o = |pc_i[ALIGN_W-1:0];
    next_pc_o  = seq_pc;
    taken_o    = 1'b0;
    if (flow == FLOW_JUMP) begin
      next_pc_o = jmp_tgt;
      taken_o   = 1'b1;
    end else if (br_hit) begin
      next_pc_o = br_tgt;
      taken_o   = 1'b1;
    end
  end

  generate
    if (REG_STAGE) begin : g_pc_reg
      logic [XLEN-1:0] pc_d;
      logic [XLEN-1:0] pc_q;

      always_comb begin
        pc_d = pc_q;
        if (pc_en) pc_d = next_pc_o;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      assign pc_q_o = pc_q;
    end else begin : g_pc_pass
      assign pc_q_o = next_pc_o;
    end
  endgenerate
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter bit REG_STAGE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc_en,
  input logic [XLEN-1:0]  pc_i,
  input logic [OPC_W-1:0] opcode,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  rt_val_i,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             taken_o,
  input logic [XLEN-1:0]  pc_q_o
);
  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_JUMP) |-> taken_o);

  // R1
  other_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode != OPC_JUMP && opcode != OPC_BEQ && opcode != OPC_BNE)
      |-> (!taken_o && next_pc_o == pc_i + 32'd4));

  // R6
  beq_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BEQ && rs_val_i != rt_val_i) |-> !taken_o);

  // R6
  bne_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BNE && rs_val_i == rt_val_i) |-> !taken_o);

  // R5
  bne_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BNE && rs_val_i != rt_val_i) |-> taken_o);

  // R6
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> (next_pc_o == pc_i + 32'd4));

  generate
    if (REG_STAGE) begin : g_reg_chk
      // R9
      pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |=> (pc_q_o == $past(next_pc_o)));

      // R9
      pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> $stable(pc_q_o));
    end
  endgenerate
endmodule

bind npc_unit npc_unit_chk #(.REG_STAGE(REG_STAGE)) u_npc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_en    (pc_en),
  .pc_i     (pc_i),
  .opcode   (instr_i[31:26]),
  .rs_val_i (rs_val_i),
  .rt_val_i (rt_val_i),
  .next_pc_o(next_pc_o),
  .taken_o  (taken_o),
  .pc_q_o   (pc_q_o)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk;
  logic        rst_n;
  logic        pc_en;
  logic [31:0] pc_i;
  logic [31:0] instr_i;
  logic [31:0] rs_val_i;
  logic [31:0] rt_val_i;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        misalign_o;
  logic [31:0] pc_q_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_q;
  bit done = 0;

  typedef struct {
    logic [31:0] nxt;
    logic        tkn;
    logic        mis;
    logic [31:0] q;
    string       tag;
  } exp_t;

  exp_t sb[$];

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .pc_en(pc_en), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .misalign_o(misalign_o), .pc_q_o(pc_q_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Model written from the requirements
  function automatic void model(input logic [31:0] pc, input logic [31:0] ins,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] nxt, output logic tkn);
    logic [31:0] seq;
    logic [31:0] off;
    seq = pc + 32'd4;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    nxt = seq;
    tkn = 1'b0;
    case (ins[31:26])
      6'd2: begin nxt = {seq[31:28], ins[25:0], 2'b00}; tkn = 1'b1; end
      6'd4: if (a == b) begin nxt = seq + off; tkn = 1'b1; end
      6'd5: if (a != b) begin nxt = seq + off; tkn = 1'b1; end
      default: ;
    endcase
  endfunction

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b; pc_en = en;
    model(pc, ins, a, b, e.nxt, e.tkn);
    e.mis = (pc[1:0] != 2'b00);
    if (en) model_q = e.nxt;
    e.q = model_q;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare once the edge has settled
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check32(e.tag, "next_pc", next_pc_o, e.nxt);
      check32(e.tag, "taken", {31'd0, taken_o}, {31'd0, e.tkn});
      check32(e.tag, "misalign", {31'd0, misalign_o}, {31'd0, e.mis});
      check32(e.tag, "pc_q", pc_q_o, e.q);
    end
  end

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd16, 5'd17, imm};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pc_en = 1'b0; pc_i = '0; instr_i = '0; rs_val_i = '0; rt_val_i = '0;
    model_q = '0;
    repeat (3) @(posedge clk);
    #1;
    check32("R9", "reset pc_q", pc_q_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 other opcodes go sequential
    drive(32'h0001_3880, {6'd0, 20'h12345, 6'd32}, 32'd1, 32'd1, 1'b1, "R1");
    drive(32'h0001_3884, itype(6'd35, 16'h0000), 32'd0, 32'd0, 1'b1, "R1");
    drive(32'h0000_2000, itype(6'd3, 16'h0010), 32'd0, 32'd0, 1'b1, "R1");
    // R2 wraparound
    drive(32'hFFFF_FFFC, itype(6'd8, 16'h0001), 32'd0, 32'd0, 1'b1, "R2");
    // R3 jumps
    drive(32'h0001_3894, {6'd2, 26'd20000}, 32'd7, 32'd9, 1'b1, "R3");
    drive(32'hA000_0000, {6'd2, 26'd5}, 32'd0, 32'd0, 1'b1, "R3");
    // R10 region taken from PC+4
    drive(32'h0FFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0, 1'b1, "R10");
    // R4 beq equal
    drive(32'h0000_1000, itype(6'd4, 16'h0003), 32'h55, 32'h55, 1'b1, "R4");
    // R6 beq unequal
    drive(32'h0000_1000, itype(6'd4, 16'h0003), 32'h55, 32'h54, 1'b1, "R6");
    // R5 bne differ (loop exit)
    drive(32'h0001_388C, itype(6'd5, 16'h0002), 32'h8000_0000, 32'h0, 1'b1, "R5");
    // R6 bne equal
    drive(32'h0001_388C, itype(6'd5, 16'h0002), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, "R6");
    // R7 negative offsets
    drive(32'h0001_3898, itype(6'd5, 16'hFFFA), 32'd1, 32'd2, 1'b1, "R7");
    drive(32'h0010_0000, itype(6'd4, 16'h8000), 32'd3, 32'd3, 1'b1, "R7");
    drive(32'h0000_0000, itype(6'd4, 16'hFFFF), 32'd3, 32'd3, 1'b1, "R7");
    // R8 misaligned PCs
    drive(32'h0000_1001, itype(6'd0, 16'h0000), 32'd0, 32'd0, 1'b1, "R8");
    drive(32'h0000_1002, {6'd2, 26'd64}, 32'd0, 32'd0, 1'b1, "R8");
    drive(32'h0000_1003, itype(6'd5, 16'h0004), 32'd1, 32'd0, 1'b1, "R8");
    // R9 hold with enable low
    drive(32'h0000_4000, {6'd2, 26'd999}, 32'd0, 32'd0, 1'b0, "R9");
    drive(32'h0000_5000, itype(6'd0, 16'h0), 32'd0, 32'd0, 1'b0, "R9");
    drive(32'h0000_6000, itype(6'd4, 16'h0010), 32'd4, 32'd4, 1'b1, "R9");
    repeat (2) @(posedge clk);
    #3;
    // R9 asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_q = '0;
    check32("R9", "async clear pc_q", pc_q_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(32'h0000_7000, itype(6'd0, 16'h0), 32'd0, 32'd0, 1'b1, "R9");
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule